// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters over the one bidirectional data wire of an asynchronous smart card link. It handles one direction at a time. A character is a low start bit, eight data bits and one parity bit. Each bit lasts one elementary time unit (etu), and an etu is a programmable number of clock cycles. The wire is open-drain. The block asserts a pull-low enable, reads the wire back through a synchronizer, and leaves the wire released (high) when idle.

Three independent controls set the character convention: bit order, data inversion and parity sense. Inversion applies only to the eight data bits. The parity bit always makes the count of logical ones (data plus parity) even, or odd when the parity-sense control is set. All three clear gives the direct convention. All three set gives the inverse convention.

In normal mode the receiver pulls the wire low for one etu after a character with bad parity. The transmitter watches for that pulse and repeats the character. In block mode no error pulse is driven and no character is repeated. The parity-error flag is still raised in block mode, and transmit completion is reported at a fixed 11.5 etu. The receiver listens at all times, including to the block's own transmissions, so a loopback decodes every sent character.

Top module: `sc_card_xcvr`

## Requirements
- R1: After reset the outputs are as follows: `line_drive_low`=0, `tx_busy`=0, `tx_done`=0, `par_err`=0 and `overrun`=0.
- R2: Timing of a sent character.
  - A character accepted on a clock edge starts its start bit right after that edge.
  - It is sent as start (low), eight data bits, then parity. Each bit lasts `etu_div` cycles.
  - The wire is released after the parity bit.
- R3: With `cfg_msb_first`=1, data bit 7 is sent first. With `cfg_msb_first`=0, data bit 0 is sent first.
- R4: Data levels, inversion and parity.
  - With `cfg_invert`=0 a data 1 is a high wire. With `cfg_invert`=1 a data 1 is a low wire.
  - The parity bit is never inverted. Its wire level equals the XOR of the eight data bits XOR `cfg_par_odd`.
- R5: Decoding the two initial characters, and the `rx_valid` pulse.
  - Direct: the wire sequence after start is high, high, low, high, high, high, low, low, then parity high. With all three convention controls 0, this decodes to 0x3B.
  - Inverse: the wire sequence after start is high, high, six lows, then parity high. With all three convention controls 1, this decodes to 0x3F.
  - `rx_valid` pulses for exactly one cycle per character.
- R6: The receiver decodes the block's own transmissions to the original byte, for any convention setting.
- R7: A parity mismatch sets `par_err`. It stays set until `err_clr` is asserted.
- R8: If `par_err` is still set when the next character's parity bit is sampled, `overrun` is set. `overrun` also stays set until `err_clr`.
- R9: Normal-mode error signal.
  - After a bad-parity character, the receiver pulls the wire low from 10.5 to 11.5 etu after the start edge it detected.
  - After a good character it drives nothing.
- R10: Block mode.
  - The receiver never drives the wire.
  - `tx_done` rises 11*D + D/2 + 1 cycles after the accepting edge, where D = `etu_div`.
- R11: Normal-mode transmit completion and repeat.
  - If the wire is high at 11 etu, `tx_done` rises 12*D + 1 cycles after the accepting edge.
  - If the wire is low at 11 etu, the start bit is resent from 13*D + 1 cycles, and `tx_done` rises at 25*D + 2 cycles.
- R12: `tx_start` has no effect while `tx_busy` is high. The character already in progress is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_div | input | 16 | Clock cycles per etu (16 or more) |
| cfg_msb_first | input | 1 | Send/receive data bit 7 first |
| cfg_invert | input | 1 | Invert the eight data bits on the wire |
| cfg_par_odd | input | 1 | Odd parity sense |
| cfg_block | input | 1 | Block mode: no error pulse, no repeat |
| tx_start | input | 1 | Start sending `tx_data` when idle |
| tx_data | input | 8 | Byte to send |
| tx_busy | output | 1 | Transmitter active |
| tx_done | output | 1 | Transmit end flag, cleared by the next start |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` updated |
| rx_data | output | 8 | Last received byte |
| par_err | output | 1 | Sticky parity-error flag |
| overrun | output | 1 | Sticky flag: parity sampled while `par_err` set |
| err_clr | input | 1 | Clears `par_err` and `overrun` |
| line_in | input | 1 | Wire level read back |
| line_drive_low | output | 1 | Pull the wire low |

## Verification
Some rules are checked on every cycle:
- The wire is never pulled while the transmitter is idle.
- The receiver stays quiet in block mode.
- `tx_done` and `tx_busy` are never high together.
- `rx_valid` is a single-cycle pulse.
- `par_err` falls only on a clear, and `overrun` rises only while `par_err` is held.
- A start request made while busy leaves the held frame unchanged.

Other behaviour only the bench scenarios can show:
- The bit levels and order for each convention.
- The exact cycle at which `tx_done` rises in each mode.
- The position of the error pulse.
- The repeat after a pulled-low check point.
- The decoding of the two initial characters.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int IDX_W      = 4;

    // etu indices at which frame events occur
    localparam logic [IDX_W-1:0] ETU_START   = 4'd0;
    localparam logic [IDX_W-1:0] ETU_D_FIRST = 4'd1;
    localparam logic [IDX_W-1:0] ETU_D_LAST  = 4'd8;
    localparam logic [IDX_W-1:0] ETU_PARITY  = 4'd9;
    localparam logic [IDX_W-1:0] ETU_SIG_ON  = 4'd10;
    localparam logic [IDX_W-1:0] ETU_SIG_OFF = 4'd11;
    localparam logic [IDX_W-1:0] ETU_CHECK   = 4'd11;
    localparam logic [IDX_W-1:0] ETU_BLK_END = 4'd11;
    localparam logic [IDX_W-1:0] ETU_NRM_END = 4'd12;
    localparam logic [IDX_W-1:0] ETU_RETRY   = 4'd13;

    typedef struct packed {
        logic msb_first;
        logic invert;
        logic par_odd;
        logic block;
    } sc_cfg_t;

    typedef enum logic {TX_IDLE, TX_RUN} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_ERR} rx_state_e;

    // byte -> wire levels in time order (index 0 goes first)
    function automatic logic [DATA_BITS-1:0] to_wire(input logic [DATA_BITS-1:0] d,
                                                     input sc_cfg_t cfg);
        logic [DATA_BITS-1:0] s;
        for (int i = 0; i < DATA_BITS; i++) begin
            s[i] = (cfg.msb_first ? d[DATA_BITS-1-i] : d[i]) ^ cfg.invert;
        end
        return s;
    endfunction

    // wire levels in time order -> byte
    function automatic logic [DATA_BITS-1:0] from_wire(input logic [DATA_BITS-1:0] s,
                                                       input sc_cfg_t cfg);
        logic [DATA_BITS-1:0] d;
        d = '0;
        for (int i = 0; i < DATA_BITS; i++) begin
            if (cfg.msb_first) d[DATA_BITS-1-i] = s[i] ^ cfg.invert;
            else               d[i]             = s[i] ^ cfg.invert;
        end
        return d;
    endfunction

    function automatic logic parity_of(input logic [DATA_BITS-1:0] d, input sc_cfg_t cfg);
        return (^d) ^ cfg.par_odd;
    endfunction

    // full frame, bit 0 = start bit
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_BITS-1:0] d,
                                                          input sc_cfg_t cfg);
        return {parity_of(d, cfg), to_wire(d, cfg), 1'b0};
    endfunction

endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/sc_etu_count.sv
module sc_etu_count #(
    parameter int ETU_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic [ETU_W-1:0] div,
    output logic [ETU_W-1:0] cnt,
    output logic [IDX_W-1:0] idx,
    output logic             at_zero,
    output logic             at_half,
    output logic             at_last
);
    assign at_zero = (cnt == '0);
    assign at_half = (cnt == (div >> 1));
    assign at_last = (cnt == div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
            idx <= '0;
        end else if (en) begin
            if (at_last) begin
                cnt <= '0;
                if (idx != '1) idx <= idx + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
    import sc_pkg::*;
#(
    parameter int ETU_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sc_cfg_t              cfg,
    input  logic [ETU_W-1:0]     div,
    input  logic                 start,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 line_s,
    output logic                 drive,
    output logic                 busy,
    output logic                 done
);
    tx_state_e             st;
    logic [FRAME_BITS-1:0] sh;
    logic [FRAME_BITS-1:0] hold;
    logic                  retry;
    logic [ETU_W-1:0]      cnt;
    logic [IDX_W-1:0]      idx;
    logic                  at_zero, at_half, at_last;
    logic                  accept, restart;

    assign accept  = (st == TX_IDLE) && start;
    assign restart = (st == TX_RUN) && !cfg.block && retry &&
                     (idx == ETU_RETRY) && at_zero;

    sc_etu_count #(.ETU_W(ETU_W), .IDX_W(IDX_W)) u_tmr (
        .clk(clk), .rst(rst), .clear(accept || restart), .en(st == TX_RUN),
        .div(div), .cnt(cnt), .idx(idx),
        .at_zero(at_zero), .at_half(at_half), .at_last(at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TX_IDLE;
            sh    <= '1;
            hold  <= '1;
            retry <= 1'b0;
            done  <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (start) begin
                        hold  <= build_frame(data, cfg);
                        sh    <= build_frame(data, cfg);
                        retry <= 1'b0;
                        done  <= 1'b0;
                        st    <= TX_RUN;
                    end
                end
                default: begin
                    if (restart) begin
                        sh    <= hold;
                        retry <= 1'b0;
                    end else begin
                        if (at_last) sh <= {1'b1, sh[FRAME_BITS-1:1]};
                        if (cfg.block) begin
                            if (idx == ETU_BLK_END && at_half) begin
                                st   <= TX_IDLE;
                                done <= 1'b1;
                            end
                        end else begin
                            if (idx == ETU_CHECK && at_zero && !line_s) retry <= 1'b1;
                            if (idx == ETU_NRM_END && at_zero && !retry) begin
                                st   <= TX_IDLE;
                                done <= 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign drive = (st == TX_RUN) && !sh[0];
    assign busy  = (st == TX_RUN);

    // R12
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (st == TX_RUN && start) |=> $stable(hold));
endmodule

// File: rtl/sc_rx.sv
module sc_rx
    import sc_pkg::*;
#(
    parameter int ETU_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sc_cfg_t              cfg,
    input  logic [ETU_W-1:0]     div,
    input  logic                 line_s,
    input  logic                 err_clr,
    output logic                 valid,
    output logic [DATA_BITS-1:0] data,
    output logic                 par_err,
    output logic                 overrun,
    output logic                 err_drive
);
    rx_state_e            st;
    logic                 line_prev;
    logic [DATA_BITS-1:0] sbuf;
    logic [DATA_BITS-1:0] decoded;
    logic [ETU_W-1:0]     cnt;
    logic [IDX_W-1:0]     idx;
    logic                 at_zero, at_half, at_last;
    logic                 fall, par_sample, bad;

    assign fall       = line_prev && !line_s;
    assign decoded    = from_wire(sbuf, cfg);
    assign par_sample = (st == RX_RUN) && at_half && (idx == ETU_PARITY);
    assign bad        = par_sample && (parity_of(decoded, cfg) != line_s);

    sc_etu_count #(.ETU_W(ETU_W), .IDX_W(IDX_W)) u_tmr (
        .clk(clk), .rst(rst), .clear((st == RX_IDLE) && fall), .en(st != RX_IDLE),
        .div(div), .cnt(cnt), .idx(idx),
        .at_zero(at_zero), .at_half(at_half), .at_last(at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            line_prev <= 1'b1;
            sbuf      <= '0;
            valid     <= 1'b0;
            data      <= '0;
            par_err   <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            line_prev <= line_s;
            valid     <= 1'b0;
            if (bad)          par_err <= 1'b1;
            else if (err_clr) par_err <= 1'b0;
            if (par_sample && par_err) overrun <= 1'b1;
            else if (err_clr)          overrun <= 1'b0;
            case (st)
                RX_IDLE: if (fall) st <= RX_RUN;
                RX_RUN: begin
                    if (at_half) begin
                        if (idx == ETU_START) begin
                            if (line_s) st <= RX_IDLE;
                        end else if (idx >= ETU_D_FIRST && idx <= ETU_D_LAST) begin
                            sbuf <= {line_s, sbuf[DATA_BITS-1:1]};
                        end else if (idx == ETU_PARITY) begin
                            valid <= 1'b1;
                            data  <= decoded;
                            st    <= (bad && !cfg.block) ? RX_ERR : RX_IDLE;
                        end
                    end
                end
                default: begin
                    if (idx == ETU_SIG_OFF && at_half) st <= RX_IDLE;
                end
            endcase
        end
    end

    assign err_drive = (st == RX_ERR) &&
                       ((idx == ETU_SIG_ON && cnt >= (div >> 1)) || idx == ETU_SIG_OFF);

    // R5
    rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R7
    perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(par_err) |-> $past(err_clr));
    // R8
    overrun_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(par_err));
endmodule

// File: rtl/sc_card_xcvr.sv
module sc_card_xcvr
    import sc_pkg::*;
#(
    parameter int ETU_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ETU_W-1:0] etu_div,
    input  logic             cfg_msb_first,
    input  logic             cfg_invert,
    input  logic             cfg_par_odd,
    input  logic             cfg_block,
    input  logic             tx_start,
    input  logic [7:0]       tx_data,
    output logic             tx_busy,
    output logic             tx_done,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             par_err,
    output logic             overrun,
    input  logic             err_clr,
    input  logic             line_in,
    output logic             line_drive_low
);
    sc_cfg_t cfg;
    logic    line_s;
    logic    tx_drv, rx_drv;

    assign cfg = '{msb_first: cfg_msb_first, invert: cfg_invert,
                   par_odd: cfg_par_odd, block: cfg_block};

    sc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(line_in), .dout(line_s)
    );

    sc_tx #(.ETU_W(ETU_W)) u_tx (
        .clk(clk), .rst(rst), .cfg(cfg), .div(etu_div),
        .start(tx_start), .data(tx_data), .line_s(line_s),
        .drive(tx_drv), .busy(tx_busy), .done(tx_done)
    );

    sc_rx #(.ETU_W(ETU_W)) u_rx (
        .clk(clk), .rst(rst), .cfg(cfg), .div(etu_div), .line_s(line_s),
        .err_clr(err_clr), .valid(rx_valid), .data(rx_data),
        .par_err(par_err), .overrun(overrun), .err_drive(rx_drv)
    );

    assign line_drive_low = tx_drv | rx_drv;

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> !tx_drv);
    // R10
    block_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_block |-> !rx_drv);
    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !tx_busy);
endmodule

// File: tb/sim_sc_card_xcvr.sv
module sim_sc_card_xcvr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [15:0] etu_div = 16'd32;
    logic       cfg_msb_first = 0, cfg_invert = 0, cfg_par_odd = 0, cfg_block = 0;
    logic       tx_start = 0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_busy, tx_done, rx_valid, par_err, overrun;
    logic [7:0] rx_data;
    logic       err_clr = 0;
    logic       card_low = 0;
    logic       line_drive_low;
    logic       line_in;

    int checks = 0, fails = 0, cyc = 0, rx_cnt = 0, D = 32;
    logic [7:0] rx_last = 8'h00;
    bit finished = 0;

    always #2.5 clk = ~clk;
    assign line_in = ~(line_drive_low | card_low);

    sc_card_xcvr u0 (
        .clk(clk), .rst(rst), .etu_div(etu_div),
        .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .cfg_par_odd(cfg_par_odd), .cfg_block(cfg_block),
        .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_data(rx_data), .par_err(par_err), .overrun(overrun),
        .err_clr(err_clr), .line_in(line_in), .line_drive_low(line_drive_low)
    );

    always @(negedge clk) if (rx_valid) begin rx_cnt++; rx_last = rx_data; end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000 && !finished) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 190000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_line(input logic [7:0] d, input bit msb,
                                            input bit inv, input bit odd);
        logic [7:0] s;
        for (int i = 0; i < 8; i++) s[i] = (msb ? d[7-i] : d[i]) ^ inv;
        return {(^d) ^ odd, s, 1'b0};
    endfunction

    task automatic set_cfg(input bit msb, input bit inv, input bit odd, input bit blk);
        @(negedge clk);
        cfg_msb_first = msb; cfg_invert = inv; cfg_par_odd = odd; cfg_block = blk;
    endtask

    // send a byte, capture wire, check timing and loopback
    task automatic run_tx(input logic [7:0] d, input bit spurious, input bit pull_err,
                          input string tag);
        logic [9:0] cap = '0;
        logic [9:0] exp;
        int done_n = -1, rx0, exp_done;
        bit gap_ok = 1, restart_ok = 1;
        rx0 = rx_cnt;
        exp = exp_line(d, cfg_msb_first, cfg_invert, cfg_par_odd);
        @(negedge clk); tx_data = d; tx_start = 1;
        @(posedge clk);
        for (int n = 0; n < 30 * D && done_n < 0; n++) begin
            @(negedge clk);
            if (n == 0) tx_start = 0;
            if (spurious && n == 4 * D) begin tx_start = 1; tx_data = ~d; end
            if (spurious && n == 4 * D + 1) tx_start = 0;
            if (pull_err && n == 11 * D - D / 8) card_low = 1;
            if (pull_err && n == 11 * D + D / 8) card_low = 0;
            if (pull_err && n == 13 * D && line_drive_low) gap_ok = 0;
            if (pull_err && n == 13 * D + 1 && !line_drive_low) restart_ok = 0;
            for (int k = 0; k < 10; k++)
                if (n == k * D + D / 2) cap[k] = ~line_drive_low;
            if (tx_done) done_n = n;
        end
        // R2 R3 R4: wire levels at mid-bit in time order
        chk(cap == exp, {"R2/R3/R4 wire ", tag}, cap, exp);
        if (cfg_block) exp_done = 11 * D + D / 2 + 1;
        else if (pull_err) exp_done = 25 * D + 2;
        else exp_done = 12 * D + 1;
        // R10 / R11 done timing
        chk(done_n == exp_done, {(cfg_block ? "R10" : "R11"), " done ", tag}, done_n, exp_done);
        if (pull_err) begin
            chk(gap_ok && restart_ok, "R11 repeat start at 13 etu", {gap_ok, restart_ok}, 3);
        end
        repeat (2 * D) @(negedge clk);
        // R6 loopback
        chk(rx_cnt == rx0 + (pull_err ? 2 : 1) && rx_last == d, {"R6 loop ", tag},
            rx_last, d);
        chk(!par_err, {"R6 no parity error ", tag}, par_err, 0);
    endtask

    // drive a frame from the card side and watch the block's pull-low
    task automatic card_frame(input logic [9:0] f, output bit d_early, output bit d_m1,
                              output bit d_m2, output bit d_late, output bit d_any);
        d_early = 0; d_m1 = 0; d_m2 = 0; d_late = 0; d_any = 0;
        for (int n = 0; n < 14 * D; n++) begin
            card_low = (n < 10 * D) ? ~f[n / D] : 1'b0;
            if (line_drive_low) d_any = 1;
            if (n == 10 * D + D / 4)     d_early = line_drive_low;
            if (n == 10 * D + 3 * D / 4) d_m1 = line_drive_low;
            if (n == 11 * D + D / 4)     d_m2 = line_drive_low;
            if (n == 12 * D)             d_late = line_drive_low;
            @(negedge clk);
        end
        card_low = 0;
    endtask

    task automatic clear_err;
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
    endtask

    initial begin
        bit e, m1, m2, l, a;
        int rx0;
        logic [9:0] f;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!line_drive_low && !tx_busy && !tx_done && !par_err && !overrun,
            "R1 reset outputs", {line_drive_low, tx_busy, tx_done, par_err, overrun}, 0);

        // R5 direct initial character
        set_cfg(0, 0, 0, 0);
        rx0 = rx_cnt;
        card_frame(10'b1_00111011_0, e, m1, m2, l, a);
        chk(rx_cnt == rx0 + 1 && rx_last == 8'h3B, "R5 direct TS", rx_last, 8'h3B);
        chk(!par_err && !a, "R9 no signal on good parity", {par_err, a}, 0);

        // R5 inverse initial character
        set_cfg(1, 1, 1, 0);
        rx0 = rx_cnt;
        card_frame(10'b1_00000011_0, e, m1, m2, l, a);
        chk(rx_cnt == rx0 + 1 && rx_last == 8'h3F, "R5 inverse TS", rx_last, 8'h3F);
        chk(!par_err, "R5 inverse TS parity", par_err, 0);

        // directed loopbacks
        set_cfg(0, 0, 0, 0); run_tx(8'hA5, 0, 0, "direct normal");
        set_cfg(1, 1, 1, 1); run_tx(8'h5C, 0, 0, "inverse block");
        set_cfg(1, 0, 0, 0); run_tx(8'h81, 0, 0, "msb first only");
        // R12 start during busy ignored
        set_cfg(0, 0, 0, 0); run_tx(8'h3C, 1, 0, "R12 busy start");
        // R11 repeat after pulled-low check point
        set_cfg(0, 1, 0, 0); run_tx(8'hE7, 0, 1, "R11 repeat");

        // R7 R9 bad parity in normal mode
        set_cfg(0, 0, 0, 0);
        f = exp_line(8'h42, 0, 0, 0); f[9] = ~f[9];
        card_frame(f, e, m1, m2, l, a);
        chk(par_err && !overrun, "R7 parity error set", {par_err, overrun}, 2);
        chk(!e && m1 && m2 && !l, "R9 error signal window", {e, m1, m2, l}, 4'b0110);
        // R8 second bad frame with flag still set
        card_frame(f, e, m1, m2, l, a);
        chk(par_err && overrun, "R8 overrun set", {par_err, overrun}, 3);
        repeat (5 * D) @(negedge clk);
        chk(par_err && overrun, "R7 flags held", {par_err, overrun}, 3);
        clear_err();
        chk(!par_err && !overrun, "R7 err_clr clears", {par_err, overrun}, 0);

        // R10 bad parity in block mode: flag only, no line activity
        set_cfg(1, 1, 1, 1);
        f = exp_line(8'h99, 1, 1, 1); f[9] = ~f[9];
        card_frame(f, e, m1, m2, l, a);
        chk(par_err && !a, "R10 block no error signal", {par_err, a}, 2);
        clear_err();

        // random loopbacks over divisors and conventions
        for (int it = 0; it < 30; it++) begin
            logic [7:0] d;
            int sel;
            sel = $urandom_range(0, 3);
            D = (sel == 0) ? 16 : (sel == 1) ? 20 : (sel == 2) ? 32 : 37;
            @(negedge clk); etu_div = 16'(D);
            set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            d = 8'($urandom_range(0, 255));
            run_tx(d, 0, 0, "random");
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule